// File: doc/BRIEF.md
# Configurable Binary Counter

A synchronous binary counter whose word length, counting direction and every control polarity are fixed when it is elaborated. The count register spans all 2^WIDTH values from all zeros to all ones and wraps in both directions. Around the register sit four controls: an asynchronous clear, a synchronous parallel load, a count enable and a direction select. Each control has a parameter that sets its active level. The clear and the load can also be marked unused, and the block then ignores the pin. A terminal-count flag reports that the count is all ones. The active clock edge is set by a parameter.

Each cycle a small selector picks one of four named operations. Clear is handled outside these operations, because it is asynchronous and acts as an override.
- `OP_LOAD`: taken whenever the load is active.
- `OP_INC`: taken when the counter is enabled, not loading, and the direction is up.
- `OP_DEC`: taken when the counter is enabled, not loading, and the direction is down.
- `OP_HOLD`: taken otherwise.

The next-value stage applies the selected operation. The register takes the result on the active edge, and the terminal flag is registered from that same next value. The transitions follow a fixed priority: clear, then load, then enabled counting, then hold.

Top module: `cfg_bin_counter`

## Requirements
- R1: The clear forces the count to zero and the terminal flag low at once, without waiting for a clock edge. CLR_POL selects the active level: 0 is active low, 1 is active high, 2 ignores the pin.
- R2: An active load stores `load_val` on the active edge, whatever the level of the enable. LD_POL selects the active level: 0 is active low, 1 is active high, 2 ignores the pin.
- R3: With the load inactive and the enable inactive, the count holds its value. EN_POL selects the enable's active level: 0 is active low, 1 is active high.
- R4: In up mode (DIR_MODE=0), each enabled edge adds one, and all ones wraps to zero.
- R5: In down mode (DIR_MODE=1), each enabled edge subtracts one, and zero wraps to all ones. `dir_up` has no effect in this mode.
- R6: In up/down mode (DIR_MODE=2), an enabled edge counts up when `dir_up` is 1 and down when it is 0.
- R7: With TC_MODE=1, `term_cnt` is high exactly when `count` is all ones, and it updates on the same edge as `count`. With TC_MODE=2, `term_cnt` is tied low.
- R8: EDGE_SEL=0 updates the counter on the rising edge of `clk`, and EDGE_SEL=1 on the falling edge. The other edge changes nothing.
- R9: The clear takes priority over the load: while the clear is active, an active load leaves the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is set by EDGE_SEL |
| clr | input | 1 | Asynchronous clear, level set by CLR_POL |
| cnt_en | input | 1 | Count enable, level set by EN_POL |
| load | input | 1 | Synchronous load, level set by LD_POL |
| load_val | input | WIDTH | Value stored by a load |
| dir_up | input | 1 | Direction in up/down mode; 1 counts up |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | High when the count is all ones |

## Verification
The bench builds three instances, each with a different parameter set.
- The first is 4 bits wide in up/down mode on the rising edge, with an active-low clear and active-high enable and load. It covers runtime direction changes, wrap in both directions, the priority of load over enable, and an asynchronous clear applied mid-cycle.
- The second is 3 bits wide, fixed down, and counts on the falling edge, with an active-high clear and an active-low enable and load. It shows that the inverted polarities work, that the non-active edge changes nothing, and that the direction pin is ignored.
- The third is 2 bits wide, fixed up, with the load marked unused and the terminal flag omitted. It shows that an unused pin is ignored and that the flag stays low at all ones.

// File: rtl/cfg_bin_counter_pkg.sv
package cfg_bin_counter_pkg;

    // Operation selected for the coming active edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } cnt_op_e;

    // Direction mode codes
    localparam int DIR_UP     = 0;
    localparam int DIR_DOWN   = 1;
    localparam int DIR_UPDOWN = 2;

    // Control polarity codes
    localparam int POL_LOW    = 0;
    localparam int POL_HIGH   = 1;
    localparam int POL_UNUSED = 2;

endpackage

// File: rtl/cfg_pol_norm.sv
module cfg_pol_norm #(
    parameter int POL = 1
) (
    input  logic pin,
    output logic act
);
    import cfg_bin_counter_pkg::*;

    generate
        if (POL == POL_LOW) begin : g_low
            assign act = ~pin;
        end else if (POL == POL_HIGH) begin : g_high
            assign act = pin;
        end else begin : g_unused
            assign act = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cfg_op_sel.sv
module cfg_op_sel #(
    parameter int DIR_MODE = 2
) (
    input  logic                          ld_act,
    input  logic                          en_act,
    input  logic                          dir_up,
    output cfg_bin_counter_pkg::cnt_op_e  op
);
    import cfg_bin_counter_pkg::*;

    logic go_up;

    generate
        if (DIR_MODE == DIR_UP) begin : g_up
            assign go_up = 1'b1;
        end else if (DIR_MODE == DIR_DOWN) begin : g_down
            assign go_up = 1'b0;
        end else begin : g_updown
            assign go_up = dir_up;
        end
    endgenerate

    // Priority: load, then enabled count, then hold
    always_comb begin
        if (ld_act) begin
            op = OP_LOAD;
        end else if (en_act) begin
            op = go_up ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cfg_next_val.sv
module cfg_next_val #(
    parameter int WIDTH = 8
) (
    input  cfg_bin_counter_pkg::cnt_op_e op,
    input  logic [WIDTH-1:0]             cur,
    input  logic [WIDTH-1:0]             ld_data,
    output logic [WIDTH-1:0]             nxt
);
    import cfg_bin_counter_pkg::*;

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = ld_data;
            OP_INC:  nxt = cur + ONE;
            OP_DEC:  nxt = cur - ONE;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/cfg_bin_counter.sv
module cfg_bin_counter #(
    parameter int WIDTH    = 8,
    parameter int DIR_MODE = 2,
    parameter int CLR_POL  = 0,
    parameter int EN_POL   = 1,
    parameter int LD_POL   = 1,
    parameter int EDGE_SEL = 0,
    parameter int TC_MODE  = 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             cnt_en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dir_up,
    output logic [WIDTH-1:0] count,
    output logic             term_cnt
);
    import cfg_bin_counter_pkg::*;

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    logic             clr_act;
    logic             en_act;
    logic             ld_act;
    cnt_op_e          op;
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_nxt;
    logic             tc_r;
    logic             tc_nxt;

    cfg_pol_norm #(.POL(CLR_POL)) u_clr_pol (.pin(clr),    .act(clr_act));
    cfg_pol_norm #(.POL(EN_POL))  u_en_pol  (.pin(cnt_en), .act(en_act));
    cfg_pol_norm #(.POL(LD_POL))  u_ld_pol  (.pin(load),   .act(ld_act));

    cfg_op_sel #(.DIR_MODE(DIR_MODE)) u_op_sel (
        .ld_act (ld_act),
        .en_act (en_act),
        .dir_up (dir_up),
        .op     (op)
    );

    cfg_next_val #(.WIDTH(WIDTH)) u_next (
        .op      (op),
        .cur     (q_r),
        .ld_data (load_val),
        .nxt     (q_nxt)
    );

    // Terminal flag decoded from the next value
    generate
        if (TC_MODE == 1) begin : g_tc_on
            assign tc_nxt = (q_nxt == ALL_ONES);
        end else begin : g_tc_off
            assign tc_nxt = 1'b0;
        end
    endgenerate

    // State register on the selected edge
    generate
        if (EDGE_SEL == 0) begin : g_rise
            always_ff @(posedge clk or posedge clr_act) begin
                if (clr_act) begin
                    q_r  <= ZERO;
                    tc_r <= 1'b0;
                end else begin
                    q_r  <= q_nxt;
                    tc_r <= tc_nxt;
                end
            end
        end else begin : g_fall
            always_ff @(negedge clk or posedge clr_act) begin
                if (clr_act) begin
                    q_r  <= ZERO;
                    tc_r <= 1'b0;
                end else begin
                    q_r  <= q_nxt;
                    tc_r <= tc_nxt;
                end
            end
        end
    endgenerate

    always_comb begin
        count    = q_r;
        term_cnt = tc_r;
    end

    // Checks, sampled on the active edge
    logic smp_clk;
    assign smp_clk = (EDGE_SEL == 0) ? clk : ~clk;

    logic step_up;
    logic step_dn;
    assign step_up = (DIR_MODE == DIR_UP) || ((DIR_MODE == DIR_UPDOWN) && dir_up);
    assign step_dn = (DIR_MODE == DIR_DOWN) || ((DIR_MODE == DIR_UPDOWN) && !dir_up);

    AST_CLEAR_ZERO: assert property (@(posedge smp_clk)
        clr_act |-> (count == ZERO && !term_cnt)); // R1

    AST_LOAD_TAKES: assert property (@(posedge smp_clk) disable iff (clr_act)
        ld_act |=> (count == $past(load_val))); // R2

    AST_IDLE_HOLD: assert property (@(posedge smp_clk) disable iff (clr_act)
        (!ld_act && !en_act) |=> $stable(count)); // R3

    AST_STEP_UP: assert property (@(posedge smp_clk) disable iff (clr_act)
        (!ld_act && en_act && step_up) |=> (count == $past(count) + ONE)); // R4 R6

    AST_STEP_DOWN: assert property (@(posedge smp_clk) disable iff (clr_act)
        (!ld_act && en_act && step_dn) |=> (count == $past(count) - ONE)); // R5

    AST_TC_DECODE: assert property (@(posedge smp_clk) disable iff (clr_act)
        term_cnt == ((TC_MODE == 1) && (count == ALL_ONES))); // R7

endmodule

// File: tb/cfg_bin_counter_tb_top.sv
`timescale 1ns/1ps
module cfg_bin_counter_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Instance A: 4-bit up/down, rising, clear low, enable high, load high
    logic       clr_a, en_a, ld_a, dir_a, tc_a;
    logic [3:0] d_a, q_a;
    cfg_bin_counter #(.WIDTH(4), .DIR_MODE(2), .CLR_POL(0), .EN_POL(1),
                      .LD_POL(1), .EDGE_SEL(0), .TC_MODE(1)) dut_i (
        .clk(clk), .clr(clr_a), .cnt_en(en_a), .load(ld_a), .load_val(d_a),
        .dir_up(dir_a), .count(q_a), .term_cnt(tc_a));

    // Instance B: 3-bit down, falling, clear high, enable low, load low
    logic       clr_b, en_b, ld_b, dir_b, tc_b;
    logic [2:0] d_b, q_b;
    cfg_bin_counter #(.WIDTH(3), .DIR_MODE(1), .CLR_POL(1), .EN_POL(0),
                      .LD_POL(0), .EDGE_SEL(1), .TC_MODE(1)) dut_b_i (
        .clk(clk), .clr(clr_b), .cnt_en(en_b), .load(ld_b), .load_val(d_b),
        .dir_up(dir_b), .count(q_b), .term_cnt(tc_b));

    // Instance C: 2-bit up, rising, load unused, flag omitted
    logic       clr_c, en_c, ld_c, dir_c, tc_c;
    logic [1:0] d_c, q_c;
    cfg_bin_counter #(.WIDTH(2), .DIR_MODE(0), .CLR_POL(0), .EN_POL(1),
                      .LD_POL(2), .EDGE_SEL(0), .TC_MODE(2)) dut_c_i (
        .clk(clk), .clr(clr_c), .cnt_en(en_c), .load(ld_c), .load_val(d_c),
        .dir_up(dir_c), .count(q_c), .term_cnt(tc_c));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic a_step(input logic ld, input logic en, input logic dir, input logic [3:0] d);
        @(negedge clk);
        ld_a = ld; en_a = en; dir_a = dir; d_a = d;
        @(posedge clk); #1;
    endtask

    task automatic b_step(input logic ld_n, input logic en_n, input logic [2:0] d);
        @(posedge clk);
        ld_b = ld_n; en_b = en_n; d_b = d;
        @(negedge clk); #1;
    endtask

    task automatic t_reset;
        // R1, R9: clear active, load active on A with data 15
        @(negedge clk);
        ld_a = 1; en_a = 1; d_a = 4'd15;
        @(posedge clk); #1;
        chk("R1 count A in clear", q_a, 0);
        chk("R1 flag A in clear", tc_a, 0);
        chk("R9 load under clear A", q_a, 0);
        chk("R1 count B in clear", q_b, 0);
        chk("R1 count C in clear", q_c, 0);
    endtask

    task automatic t_a_main;
        @(negedge clk); clr_a = 1;
        a_step(1, 0, 1, 4'd9);  chk("R2 load while disabled", q_a, 9);
        a_step(0, 0, 1, 4'd0);  chk("R3 hold when idle", q_a, 9);
        a_step(0, 1, 1, 4'd0);  chk("R6 up when dir=1", q_a, 10);
        a_step(1, 0, 1, 4'd14); chk("R2 load 14", q_a, 14);
        chk("R7 flag low at 14", tc_a, 0);
        a_step(0, 1, 1, 4'd0);  chk("R7 reach all ones", q_a, 15);
        chk("R7 flag high at 15", tc_a, 1);
        a_step(0, 1, 1, 4'd0);  chk("R4 wrap up to 0", q_a, 0);
        chk("R7 flag low after wrap", tc_a, 0);
        a_step(0, 1, 0, 4'd0);  chk("R5 wrap down to 15", q_a, 15);
        chk("R7 flag high counting down", tc_a, 1);
        a_step(0, 1, 0, 4'd0);  chk("R6 down when dir=0", q_a, 14);
        a_step(1, 1, 1, 4'd3);  chk("R2 load beats enable", q_a, 3);
        // R1 asynchronous: apply clear between edges
        @(negedge clk); ld_a = 0; en_a = 1; clr_a = 0; #1;
        chk("R1 async clear A", q_a, 0);
        @(negedge clk); clr_a = 1; en_a = 0;
    endtask

    task automatic t_b_main;
        @(posedge clk); clr_b = 0; en_b = 1; ld_b = 1; dir_b = 1;
        @(negedge clk); #1;
        chk("R3 B idle after clear", q_b, 0);
        b_step(1, 0, 3'd0); chk("R5 wrap down B (dir pin ignored)", q_b, 7);
        chk("R7 flag B at 7", tc_b, 1);
        b_step(1, 0, 3'd0); chk("R5 count down B", q_b, 6);
        chk("R7 flag B low", tc_b, 0);
        b_step(1, 1, 3'd0); chk("R3 hold B enable inactive", q_b, 6);
        b_step(0, 1, 3'd2); chk("R2 active-low load B", q_b, 2);
        // R8: falling-edge counter ignores the rising edge
        @(negedge clk); #1; ld_b = 1; en_b = 0;
        @(posedge clk); #1;
        chk("R8 no change on rising edge", q_b, 2);
        @(negedge clk); #1;
        chk("R8 change on falling edge", q_b, 1);
        en_b = 1;
        // R1 active-high clear
        clr_b = 1; #1;
        chk("R1 async clear B", q_b, 0);
    endtask

    task automatic t_c_main;
        @(negedge clk); clr_c = 1; en_c = 1; ld_c = 0;
        @(posedge clk); #1; chk("R4 C up 1", q_c, 1);
        @(posedge clk); #1; chk("R4 C up 2", q_c, 2);
        @(posedge clk); #1; chk("R4 C up 3", q_c, 3);
        chk("R7 flag omitted stays low", tc_c, 0);
        @(posedge clk); #1; chk("R4 C wrap to 0", q_c, 0);
        @(negedge clk); en_c = 0; ld_c = 1; d_c = 2'd2;
        @(posedge clk); #1; chk("R2 unused load ignored", q_c, 0);
        @(negedge clk); en_c = 1;
        @(posedge clk); #1; chk("R2 unused load ignored while enabled", q_c, 1);
    endtask

    initial begin
        clr_a = 0; en_a = 0; ld_a = 0; dir_a = 1; d_a = '0;
        clr_b = 1; en_b = 1; ld_b = 1; dir_b = 0; d_b = '0;
        clr_c = 0; en_c = 0; ld_c = 0; dir_c = 0; d_c = '0;
        repeat (2) @(posedge clk);
        t_reset();
        t_a_main();
        t_b_main();
        t_c_main();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule